// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block recovers asynchronous serial characters from a single input line and places each completed character in a small register-built queue. The line is resynchronised to the core clock, then sampled once per bit near the bit centre by a counter that runs at sixteen ticks per bit period. A character consists of a low start bit, DATA_W data bits sent least significant bit first, an optional parity bit, and one high stop bit. The queue gives double buffering: characters already received stay there while the next one shifts in.

A host reads three registers over a plain read/write strobe port, and every read returns its value one cycle later. The data register pops the queue. The status register combines live queue flags with five error flags that stay set until cleared. The level register reports the fill count. That count wraps to zero when the queue is full, so a host tells full from empty by the ready flag. Each completed character is written to the queue, including one that carries an error. The only exception is a character that arrives while the queue is full, which is dropped.

Top module: `async_rx_queue`

## Requirements
- R1: After reset the status register (offset 1) reads 0x00 and the level register (offset 2) reads 0.
- R2: A frame is a low start bit, DATA_W data bits least significant bit first, a parity bit when parity is enabled (even: the parity bit equals the XOR of the data bits; odd: its inverse), and a stop bit, each lasting OSR*DIV clocks. The received character reads back zero-extended in a 16-bit data word.
- R3: A low pulse shorter than half a bit period is rejected as a start bit, and no character is queued.
- R4: Characters come out of the data register (offset 0) in arrival order. A data read when the queue is not empty removes one entry. Status bit 0 (ready) is high exactly when the queue holds at least one entry.
- R5: A data read while ready is low returns 0x000F, leaves the queue unchanged and sets status bit 7 (underrun).
- R6: A character completed while the queue is full is dropped, sets status bit 6 (overrun) and leaves the stored entries intact.
- R7: The level register reads the entry count modulo DEPTH, which gives 0 when full. Status bit 1 (full) is high when the count equals DEPTH.
- R8: Status bit 2 (almost full) is high when the free entries number AFULL_ROOM or fewer.
- R9: A stop bit sampled low sets status bit 3 (framing error). The receiver accepts no new start until the line has returned high.
- R10: With parity enabled, a received parity bit that disagrees with the parity computed from the data sets status bit 4 (parity error).
- R11: A frame in which the start, data, parity and stop samples are all low sets status bit 5 (break).
- R12: Status bits 3 to 7 stay set across reads and any number of cycles. Any write to offset 1 clears them. An error arriving in the same cycle as the write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial input line, idle high |
| reg_addr | input | 2 | Register offset: 0 data, 1 status, 2 level |
| reg_rd | input | 1 | Read strobe, data valid on reg_rdata the next cycle |
| reg_wr | input | 1 | Write strobe; at offset 1 it clears the error flags |
| reg_rdata | output | 16 | Read data, registered |

## Verification
The bench fills the queue to exactly DEPTH. A design that does not wrap the level would show DEPTH instead of 0, and one that compares the almost-full threshold the wrong way round would flag one entry early or late. It then sends one more character. A design that overwrites on overrun would return that late character in place of an older one, so the bench reads every entry back in order. It reads from an empty queue to catch a design that pops past empty or returns stale data instead of 0x000F. It sends a short low glitch to catch start validation that is missing, and sends frames with bad parity, a low stop bit and an all-low line, reading the status twice to show that the errors stay set until the clearing write.

// File: rtl/async_rx_queue_pkg.sv
package async_rx_queue_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } parity_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    localparam logic [1:0]  OFS_DATA  = 2'd0;
    localparam logic [1:0]  OFS_STAT  = 2'd1;
    localparam logic [1:0]  OFS_LEVEL = 2'd2;
    localparam logic [15:0] EMPTY_READ_WORD = 16'h000F;

    // sticky error flags, LSB first: frame, parity, break, overrun, underrun
    typedef struct packed {
        logic underrun;
        logic overrun;
        logic brk;
        logic par;
        logic frame;
    } err_flags_t;

    // expected parity bit over the lowest w bits of d
    function automatic logic parity_of(input logic [8:0] d, input int unsigned w,
                                       input parity_e mode);
        logic p;
        p = 1'b0;
        for (int i = 0; i < 9; i++) begin
            if (i < w) p = p ^ d[i];
        end
        return (mode == PAR_ODD) ? ~p : p;
    endfunction

endpackage

// File: rtl/arq_bit_engine.sv
module arq_bit_engine
    import async_rx_queue_pkg::*;
#(
    parameter int      DATA_W      = 8,
    parameter parity_e PARITY      = PAR_EVEN,
    parameter int      OSR         = 16,
    parameter int      DIV         = 1,
    parameter int      SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    output logic              ch_vld,
    output logic [DATA_W-1:0] ch_data,
    output logic              ch_frame,
    output logic              ch_par,
    output logic              ch_brk
);
    localparam int OSW = $clog2(OSR);
    localparam int BCW = $clog2(DATA_W + 1);
    localparam logic [OSW-1:0] OS_LAST = OSW'(OSR - 1);
    localparam logic [OSW-1:0] OS_HALF = OSW'(OSR / 2 - 1);
    localparam logic [BCW-1:0] BC_LAST = BCW'(DATA_W - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line;
    logic                   tick;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
    assign line = sync_q[SYNC_STAGES-1];

    generate
        if (DIV == 1) begin : g_tick_every
            assign tick = 1'b1;
        end else begin : g_tick_div
            localparam int DVW = $clog2(DIV);
            logic [DVW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)                         div_q <= '0;
                else if (div_q == DVW'(DIV - 1)) div_q <= '0;
                else                             div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DVW'(DIV - 1));
        end
    endgenerate

    rx_state_e         state;
    logic [OSW-1:0]    os_q;
    logic [BCW-1:0]    bc_q;
    logic [DATA_W-1:0] sh_q;
    logic              par_rx_q;
    logic              any_hi_q;
    logic              at_last;

    assign at_last = (os_q == OS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            os_q     <= '0;
            bc_q     <= '0;
            sh_q     <= '0;
            par_rx_q <= 1'b0;
            any_hi_q <= 1'b0;
            ch_vld   <= 1'b0;
            ch_data  <= '0;
            ch_frame <= 1'b0;
            ch_par   <= 1'b0;
            ch_brk   <= 1'b0;
        end else begin
            ch_vld <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line) begin
                            state <= RX_START;
                            os_q  <= '0;
                        end
                    end
                    RX_START: begin
                        if (os_q == OS_HALF) begin
                            os_q     <= '0;
                            bc_q     <= '0;
                            any_hi_q <= 1'b0;
                            state    <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (at_last) begin
                            os_q     <= '0;
                            sh_q     <= {line, sh_q[DATA_W-1:1]};
                            any_hi_q <= any_hi_q | line;
                            if (bc_q == BC_LAST)
                                state <= (PARITY == PAR_NONE) ? RX_STOP : RX_PAR;
                            else
                                bc_q <= bc_q + 1'b1;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (at_last) begin
                            os_q     <= '0;
                            par_rx_q <= line;
                            any_hi_q <= any_hi_q | line;
                            state    <= RX_STOP;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (at_last) begin
                            os_q     <= '0;
                            ch_vld   <= 1'b1;
                            ch_data  <= sh_q;
                            ch_frame <= !line;
                            ch_brk   <= !line && !any_hi_q;
                            ch_par   <= (PARITY != PAR_NONE) &&
                                        (par_rx_q != parity_of(9'(sh_q), DATA_W, PARITY));
                            state    <= line ? RX_IDLE : RX_HOLD;
                        end else begin
                            os_q <= os_q + 1'b1;
                        end
                    end
                    RX_HOLD: begin
                        if (line) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/arq_fifo.sv
module arq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && (cnt != CW'(DEPTH));
    assign do_pop  = pop  && (cnt != '0);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/arq_csr.sv
module arq_csr
    import async_rx_queue_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 4,
    parameter int AFULL_ROOM = 1,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [CW-1:0]     cnt,
    input  logic [DATA_W-1:0] head,
    input  logic              ch_vld,
    input  logic              ch_frame,
    input  logic              ch_par,
    input  logic              ch_brk,
    output logic              pop,
    output logic [4:0]        sticky_o,
    output logic [15:0]       reg_rdata
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] ROOM_C  = CW'(AFULL_ROOM);

    err_flags_t sticky_q, events;
    logic       ready, full, afull, data_rd, clr;
    logic [7:0] status;

    assign ready   = (cnt != '0);
    assign full    = (cnt == DEPTH_C);
    assign afull   = ((DEPTH_C - cnt) <= ROOM_C);
    assign data_rd = reg_rd && (reg_addr == OFS_DATA);
    assign pop     = data_rd && ready;
    assign clr     = reg_wr && (reg_addr == OFS_STAT);

    always_comb begin
        events          = '0;
        events.underrun = data_rd && !ready;
        events.overrun  = ch_vld && full;
        events.brk      = ch_vld && ch_brk;
        events.par      = ch_vld && ch_par;
        events.frame    = ch_vld && ch_frame;
    end

    always_ff @(posedge clk) begin
        if (rst) sticky_q <= '0;
        else     sticky_q <= (clr ? err_flags_t'('0) : sticky_q) | events;
    end

    assign sticky_o = sticky_q;
    assign status   = {sticky_q, afull, full, ready};

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                OFS_DATA:  reg_rdata <= ready ? 16'(head) : EMPTY_READ_WORD;
                OFS_STAT:  reg_rdata <= 16'(status);
                OFS_LEVEL: reg_rdata <= 16'(cnt[AW-1:0]);
                default:   reg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/async_rx_queue.sv
module async_rx_queue
    import async_rx_queue_pkg::*;
#(
    parameter int      DATA_W     = 8,
    parameter parity_e PARITY     = PAR_EVEN,
    parameter int      OSR        = 16,
    parameter int      DIV        = 1,
    parameter int      DEPTH      = 4,
    parameter int      AFULL_ROOM = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rxd,
    input  logic [1:0]  reg_addr,
    input  logic        reg_rd,
    input  logic        reg_wr,
    output logic [15:0] reg_rdata
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic              ch_vld, ch_frame, ch_par, ch_brk, fifo_pop;
    logic [DATA_W-1:0] ch_data, fifo_head;
    logic [CW-1:0]     fifo_cnt;
    logic [4:0]        sticky_bits;

    arq_bit_engine #(
        .DATA_W(DATA_W), .PARITY(PARITY), .OSR(OSR), .DIV(DIV), .SYNC_STAGES(2)
    ) engine_i (
        .clk(clk), .rst(rst), .rxd(rxd),
        .ch_vld(ch_vld), .ch_data(ch_data),
        .ch_frame(ch_frame), .ch_par(ch_par), .ch_brk(ch_brk)
    );

    arq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst(rst),
        .push(ch_vld), .din(ch_data),
        .pop(fifo_pop), .dout(fifo_head), .cnt(fifo_cnt)
    );

    arq_csr #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AFULL_ROOM(AFULL_ROOM)) csr_i (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .cnt(fifo_cnt), .head(fifo_head),
        .ch_vld(ch_vld), .ch_frame(ch_frame), .ch_par(ch_par), .ch_brk(ch_brk),
        .pop(fifo_pop), .sticky_o(sticky_bits), .reg_rdata(reg_rdata)
    );

endmodule

// File: rtl/async_rx_queue_chk.sv
module async_rx_queue_chk #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    reg_addr,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [15:0]   reg_rdata,
    input logic [CW-1:0] cnt,
    input logic          push,
    input logic [4:0]    sticky
);
    logic data_rd, stat_wr;
    assign data_rd = reg_rd && (reg_addr == 2'd0);
    assign stat_wr = reg_wr && (reg_addr == 2'd1);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R5
    empty_word_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && cnt == '0) |=> (reg_rdata == 16'h000F));

    // R5
    empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && cnt == '0) |=> sticky[4]);

    // R5
    empty_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && cnt == '0 && !push) |=> (cnt == '0));

    // R4
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && cnt != '0 && !push) |=> (cnt == $past(cnt) - 1'b1));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && cnt == CW'(DEPTH) && !data_rd) |=> (cnt == CW'(DEPTH)));

    // R12
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((sticky & $past(sticky)) == $past(sticky)));

endmodule

bind async_rx_queue async_rx_queue_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .cnt(fifo_cnt), .push(ch_vld), .sticky(sticky_bits)
);

// File: tb/async_rx_queue_tb_top.sv
`timescale 1ns/1ps
module async_rx_queue_tb_top;
    localparam int BIT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] v;

    always #2.5 clk = ~clk;

    async_rx_queue dut_i (
        .clk(clk), .rst(rst), .rxd(rxd),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic clear_status();
        @(negedge clk);
        reg_addr = 2'd1;
        reg_wr   = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic stop_v);
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(BIT);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            wait_clks(BIT);
        end
        rxd = (^d) ^ bad_par;
        wait_clks(BIT);
        rxd = stop_v;
        wait_clks(BIT);
        rxd = 1'b1;
        wait_clks(2 * BIT);
    endtask

    task automatic t_reset();
        rd(2'd1, v); check("R1 status after reset", v, 16'h0000);
        rd(2'd2, v); check("R1 level after reset", v, 16'h0000);
    endtask

    task automatic t_basic();
        send(8'hA5, 1'b0, 1'b1);
        send(8'h3C, 1'b0, 1'b1);
        rd(2'd1, v); check("R4 ready with two entries", v, 16'h0001);
        rd(2'd2, v); check("R7 level two", v, 16'h0002);
        rd(2'd0, v); check("R2 first char", v, 16'h00A5);
        rd(2'd0, v); check("R4 second char in order", v, 16'h003C);
        rd(2'd1, v); check("R4 ready low after drain", v, 16'h0000);
    endtask

    task automatic t_underrun();
        rd(2'd0, v); check("R5 empty read word", v, 16'h000F);
        rd(2'd1, v); check("R5 underrun flag", v, 16'h0080);
        rd(2'd2, v); check("R5 level unchanged", v, 16'h0000);
        clear_status();
        rd(2'd1, v); check("R12 cleared by write", v, 16'h0000);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rxd = 1'b0;
        wait_clks(4);
        rxd = 1'b1;
        wait_clks(3 * BIT);
        rd(2'd2, v); check("R3 glitch not queued", v, 16'h0000);
        rd(2'd1, v); check("R3 status idle after glitch", v, 16'h0000);
    endtask

    task automatic t_fill_overrun();
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        send(8'h33, 1'b0, 1'b1);
        rd(2'd2, v); check("R7 level three", v, 16'h0003);
        rd(2'd1, v); check("R8 almost full at one free", v, 16'h0005);
        send(8'h44, 1'b0, 1'b1);
        rd(2'd2, v); check("R7 level wraps at full", v, 16'h0000);
        rd(2'd1, v); check("R7 full with ready", v, 16'h0007);
        send(8'h77, 1'b0, 1'b1);
        rd(2'd1, v); check("R6 overrun flag", v, 16'h0047);
        rd(2'd0, v); check("R6 entry 0 kept", v, 16'h0011);
        rd(2'd0, v); check("R6 entry 1 kept", v, 16'h0022);
        rd(2'd0, v); check("R6 entry 2 kept", v, 16'h0033);
        rd(2'd0, v); check("R6 entry 3 kept", v, 16'h0044);
        rd(2'd1, v); check("R6 dropped char absent", v, 16'h0040);
        clear_status();
        rd(2'd1, v); check("R12 overrun cleared", v, 16'h0000);
    endtask

    task automatic t_parity();
        send(8'h5C, 1'b1, 1'b1);
        rd(2'd1, v); check("R10 parity error flag", v, 16'h0011);
        rd(2'd0, v); check("R10 data still queued", v, 16'h005C);
        clear_status();
    endtask

    task automatic t_framing();
        send(8'h5A, 1'b0, 1'b0);
        rd(2'd1, v); check("R9 framing error flag", v, 16'h0009);
        rd(2'd0, v); check("R9 data queued", v, 16'h005A);
        rd(2'd2, v); check("R9 single char after low stop", v, 16'h0000);
        clear_status();
    endtask

    task automatic t_break();
        send(8'h00, 1'b0, 1'b0);
        rd(2'd1, v); check("R11 break and framing", v, 16'h0029);
        wait_clks(50);
        rd(2'd1, v); check("R12 flags persist across read", v, 16'h0029);
        rd(2'd0, v); check("R11 zero char queued", v, 16'h0000);
        clear_status();
        rd(2'd1, v); check("R12 all cleared", v, 16'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(5);
        t_reset();
        t_basic();
        t_underrun();
        t_glitch();
        t_fill_overrun();
        t_parity();
        t_framing();
        t_break();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule